// File: doc/BRIEF.md
# Edge-Qualified Non-Maskable Interrupt Capture

This block turns an asynchronous, unmaskable interrupt line into a clean, held request for the core's interrupt entry sequencer. The line goes through a two-stage synchronizer. A run counter then accepts a low-to-high transition only when the line stays high for at least `MIN_HIGH` consecutive sampled clock cycles. An accepted transition sets a pending flag. The flag stays set, whatever the line does afterwards, until the entry sequencer acknowledges service.

When the core signals an instruction boundary, or the gap between two element moves of a repeated block operation, and the flag is set, the block raises a service request with the fixed interrupt type 2. While the flag is set, the block also withholds the grant for the maskable request, so the non-maskable request wins. A level that stays high gives one request only. A new qualified rising edge seen after the acknowledge gives another.

Top module: `nmi_edge_capture`

## Requirements
- R1: After reset, `nmi_pending`, `svc_req` and `irq_grant` are 0.
- R2: When `nmi_in` is first sampled high at rising edge E1 and stays high for `MIN_HIGH` samples (default 3), `nmi_pending` is 0 through edge E1+`MIN_HIGH` and reads 1 after edge E1+`MIN_HIGH`+1.
- R3: A high run of fewer than `MIN_HIGH` consecutive samples never sets `nmi_pending`.
- R4: Holding `nmi_in` high produces exactly one request. After an acknowledge, the flag stays 0 for as long as the line remains high.
- R5: A falling edge on `nmi_in` has no effect, and a set `nmi_pending` stays 1 after the line drops.
- R6: `svc_req` is 1 exactly when `nmi_pending` and `boundary` are both 1.
- R7: Whenever `svc_req` is 1, `svc_type` equals 2.
- R8: A one-cycle `svc_ack`, with no qualified edge in the same cycle, clears `nmi_pending` at the next clock edge.
- R9: If a qualified edge and `svc_ack` occur in the same cycle, `nmi_pending` stays 1.
- R10: A new qualified rising edge after an acknowledge sets `nmi_pending` again.
- R11: `irq_grant` is 1 exactly when `irq_req` and `boundary` are 1 and `nmi_pending` is 0.
- R12: Several qualified edges before one acknowledge merge into a single pending request, and one acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_in | input | 1 | Asynchronous non-maskable interrupt line |
| boundary | input | 1 | Core is at an instruction boundary or between block-move elements |
| svc_ack | input | 1 | One-cycle acknowledge from the entry sequencer when service starts |
| irq_req | input | 1 | Maskable interrupt request, already qualified by the interrupt-enable flag |
| nmi_pending | output | 1 | Latched non-maskable request awaiting service |
| svc_req | output | 1 | Non-maskable service request to the entry sequencer |
| svc_type | output | 8 | Interrupt type number sent with `svc_req` |
| irq_grant | output | 1 | Maskable request may be taken at this boundary |

## Verification
A run counter that is off by one would move the rise of `nmi_pending` by a cycle. It would also flip the accept or reject outcome at widths `MIN_HIGH-1` and `MIN_HIGH`. The width sweep and the exact edge-count check show both within one pulse. An arming flag stuck set shows as a second request while the line stays high after an acknowledge. An arming flag stuck clear shows as no request at all. A wrong clear priority shows one cycle after the collision cycle, as a dropped flag. The output gating is swept over every combination of flag, boundary and maskable request.

// File: rtl/nmi_cap_pkg.sv
package nmi_cap_pkg;
  localparam logic [7:0] NMI_TYPE = 8'd2;

  // True when the current sample completes a high run of min_high samples
  function automatic logic run_met(input int unsigned run_len, input int unsigned min_high);
    return (run_len + 1) == min_high;
  endfunction

  // Next pending state: a new edge wins over an acknowledge
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/nmi_width_qual.sv
module nmi_width_qual #(
  parameter int MIN_HIGH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic qual
);
  import nmi_cap_pkg::*;
  localparam int CW = $clog2(MIN_HIGH + 1);

  logic [CW-1:0] run_cnt;
  logic          armed;

  assign qual = lvl && armed && run_met(int'(run_cnt), MIN_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      armed   <= 1'b1;
    end else if (!lvl) begin
      run_cnt <= '0;
      armed   <= 1'b1;
    end else if (armed) begin
      if (qual) begin
        armed   <= 1'b0;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R3: an accepted edge needs the line high in the previous sample too
  p_run_before_qual_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(lvl));
  // R4: one accept per high period
  p_single_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> !qual);
endmodule

// File: rtl/nmi_pend.sv
module nmi_pend (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qual,
  input  logic       boundary,
  input  logic       svc_ack,
  input  logic       irq_req,
  output logic       pending,
  output logic       svc_req,
  output logic [7:0] svc_type,
  output logic       irq_grant
);
  import nmi_cap_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pend_next(pending, qual, svc_ack);
  end

  assign svc_req   = pending & boundary;
  assign svc_type  = NMI_TYPE;
  assign irq_grant = irq_req & boundary & ~pending;

  // R2: an accepted edge is latched at the next edge
  p_set_on_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
    qual |=> pending);
  // R5: without an acknowledge the flag holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !svc_ack) |=> pending);
  // R8: acknowledge clears when no new edge collides
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack && !qual) |=> !pending);
  // R10: the flag only rises from an accepted edge
  p_rise_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(qual));
  // R11: the non-maskable request outranks the maskable grant
  p_grant_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc_req && irq_grant));
endmodule

// File: rtl/nmi_edge_capture.sv
module nmi_edge_capture #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HIGH    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       nmi_in,
  input  logic       boundary,
  input  logic       svc_ack,
  input  logic       irq_req,
  output logic       nmi_pending,
  output logic       svc_req,
  output logic [7:0] svc_type,
  output logic       irq_grant
);
  logic nmi_lvl;
  logic edge_ok;

  nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(nmi_in), .q_sync(nmi_lvl));

  nmi_width_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
    .clk(clk), .rst_n(rst_n), .lvl(nmi_lvl), .qual(edge_ok));

  nmi_pend u_pend (
    .clk(clk), .rst_n(rst_n), .qual(edge_ok), .boundary(boundary),
    .svc_ack(svc_ack), .irq_req(irq_req), .pending(nmi_pending),
    .svc_req(svc_req), .svc_type(svc_type), .irq_grant(irq_grant));

  // R7: the type presented with a request is always 2
  p_type_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (svc_type == 8'd2));
  // R6: no request away from a boundary
  p_req_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (boundary && nmi_pending));
endmodule

// File: tb/sim_nmi_edge_capture.sv
module sim_nmi_edge_capture;
  localparam int MINH = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_in = 0, boundary = 0, svc_ack = 0, irq_req = 0;
  logic nmi_pending, svc_req, irq_grant;
  logic [7:0] svc_type;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nmi_edge_capture #(.SYNC_STAGES(2), .MIN_HIGH(MINH)) u0 (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .boundary(boundary),
    .svc_ack(svc_ack), .irq_req(irq_req), .nmi_pending(nmi_pending),
    .svc_req(svc_req), .svc_type(svc_type), .irq_grant(irq_grant));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_pulse();
    svc_ack = 1; cyc(1); svc_ack = 0;
  endtask

  initial begin
    #1_600_000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 pending", nmi_pending, 0);
    chk("R1 svc_req", svc_req, 0);
    chk("R1 irq_grant", irq_grant, 0);
    rst_n = 1; cyc(2);

    // R2: exact latency; first sample at E1, flag after E1+MINH+1
    nmi_in = 1;
    cyc(MINH + 1);
    chk("R2 not yet", nmi_pending, 0);
    cyc(1);
    chk("R2 set", nmi_pending, 1);
    nmi_in = 0; cyc(6);
    chk("R5 after fall", nmi_pending, 1);
    ack_pulse(); cyc(1);
    chk("R8 cleared", nmi_pending, 0);

    // R3/R2 width sweep
    for (int w = 1; w <= 6; w++) begin
      nmi_in = 1; cyc(w); nmi_in = 0; cyc(8);
      chk(w >= MINH ? "R2 width" : "R3 width", nmi_pending, (w >= MINH) ? 1 : 0);
      if (nmi_pending) begin ack_pulse(); cyc(1); end
      chk("R8 sweep clear", nmi_pending, 0);
    end

    // R4: held level, one request; R10 re-arm on fresh edge
    nmi_in = 1; cyc(10);
    chk("R4 first", nmi_pending, 1);
    ack_pulse();
    for (int k = 0; k < 12; k++) begin
      chk("R4 no repeat", nmi_pending, 0);
      cyc(1);
    end
    nmi_in = 0; cyc(4);
    nmi_in = 1; cyc(8); nmi_in = 0; cyc(4);
    chk("R10 rearm", nmi_pending, 1);

    // R12: second edge while pending, one ack clears
    nmi_in = 1; cyc(6); nmi_in = 0; cyc(6);
    chk("R12 merged", nmi_pending, 1);
    ack_pulse(); cyc(1);
    chk("R12 one ack", nmi_pending, 0);

    // R9: collision of edge and ack; flag set first
    nmi_in = 1; cyc(6); nmi_in = 0; cyc(6);
    chk("R9 pre", nmi_pending, 1);
    nmi_in = 1; cyc(MINH);      // E1..E3 passed; accept is in cycle after E(MINH+1)
    cyc(1);
    svc_ack = 1; cyc(1); svc_ack = 0;
    chk("R9 edge wins", nmi_pending, 1);
    nmi_in = 0; cyc(4);
    ack_pulse(); cyc(1);
    chk("R8 after R9", nmi_pending, 0);

    // R6/R7/R11 exhaustive gating sweep
    for (int p = 0; p < 2; p++) begin
      if (p == 1) begin nmi_in = 1; cyc(6); nmi_in = 0; cyc(3); end
      for (int b = 0; b < 2; b++)
        for (int q = 0; q < 2; q++) begin
          boundary = b[0]; irq_req = q[0]; #1;
          chk("R6 svc_req", svc_req, (p == 1 && b == 1) ? 1 : 0);
          if (svc_req) chk("R7 type", svc_type, 8'd2);
          chk("R11 grant", irq_grant, (q == 1 && b == 1 && p == 0) ? 1 : 0);
          cyc(1);
        end
      boundary = 0; irq_req = 0;
    end
    ack_pulse(); cyc(2);
    chk("R8 final", nmi_pending, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule